// File: doc/BRIEF.md
# Banked Shared-Memory Crossbar

This block lets twenty independent requesters share one on-chip memory that is split into sixteen separately accessible banks. Every requester has its own route to every bank, so requests that land in different banks in the same cycle are all served in that cycle. When several requesters aim at one bank, that bank's own round-robin arbiter picks a single winner. The others keep their request up and retry. No shared bus exists, so contention in one bank never delays traffic in another.

A requester presents a word address, a read/write flag, write data and a byte mask, and holds them until it sees its grant. A granted write updates the bank on that clock edge. A granted read returns its word on the requester's own response lane exactly one cycle later. A single mode input selects how a word address is split into bank and row. The fine-grained map spreads consecutive words across the banks. The coarse map gives each bank one contiguous slice of the address space. Software may flip the mode only while no request is pending. The stored contents are untouched, so the same physical cell becomes reachable under the other map's address. Bank count, bank depth, word size and requester count are all parameters. The default bank depth is small; raising it gives the full 2 MB or 4 MB capacity.

Top module: `banked_xbar`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no response is signalled. Each bank's arbiter comes out of reset favouring requester 0.
- R2: With `map_blocked` = 0, a word address selects bank = address bits [3:0] and row = bits [10:4]. With 8-byte words, bits [3:0] are byte-address bits [6:3].
- R3: With `map_blocked` = 1, bank = word-address bits [10:7] and row = bits [6:0].
- R4: A valid requester that is the only one aiming at its bank is granted in the same cycle. Any number of requesters on distinct banks are granted together.
- R5: A bank grants at most one requester per cycle, whether the contenders are reading or writing.
- R6: Each bank grants the first requesting index at or after its pointer, searching upward and wrapping after index 19. After a grant, the pointer moves to the winner plus one (wrapping to 0). A cycle with no grant leaves the pointer unchanged.
- R7: A granted read raises `rsp_valid` of that requester exactly one cycle later, with the bank word on its `rsp_rdata`. A granted write raises no response. `rsp_rdata` is zero whenever `rsp_valid` is low.
- R8: On a write, byte-mask bit k enables data bits [8k+7:8k]. Unmasked bytes keep their stored value, and an all-zero mask changes nothing.
- R9: A grant goes only to a valid requester. An ungranted requester keeps valid, address and write flag stable into the next cycle.
- R10: `map_blocked` changes only in cycles with every valid low. Bank contents survive the change, so a cell written under one map reads back under the other map's address for the same bank and row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_blocked | input | 1 | 0: word-interleaved bank map, 1: contiguous-block map |
| req_valid | input | N_MASTERS | Request pending, one bit per requester |
| req_write | input | N_MASTERS | 1 = write, 0 = read |
| req_addr | input | N_MASTERS x 11 | Word address per requester |
| req_wdata | input | N_MASTERS x 64 | Write data per requester |
| req_be | input | N_MASTERS x 8 | Byte write mask per requester |
| req_grant | output | N_MASTERS | Request accepted this cycle |
| rsp_valid | output | N_MASTERS | Read data present this cycle |
| rsp_rdata | output | N_MASTERS x 64 | Read data per requester |

## Verification
Several kinds of internal fault can occur, and each shows at the ports within one or two cycles.

- A wrong bank decode changes which address pairs collide. A sweep of one requester against every address shows this in the same cycle as the grant.
- A stale or skipped arbiter pointer puts a grant on the wrong requester. A mis-steered data mux or a lost response tag returns the wrong word, or no word, one cycle after the grant.
- A broken byte lane shows on the read that follows the masked write.
- Moving the bank cells across a mode change shows when a word written under one map is read back under the other.

// File: rtl/bxb_pkg.sv
`timescale 1ns/1ps
package bxb_pkg;
   localparam int unsigned DEF_MASTERS    = 20;
   localparam int unsigned DEF_BANKS      = 16;
   localparam int unsigned DEF_WORD_BYTES = 8;
   localparam int unsigned DEF_BANK_WORDS = 128;

   typedef enum logic {
      MAP_INTERLEAVE = 1'b0,
      MAP_BLOCKED    = 1'b1
   } map_mode_e;
endpackage

// File: rtl/bxb_bank_map.sv
`timescale 1ns/1ps
// Splits a word address into bank and row under the selected map.
module bxb_bank_map #(
   parameter  int unsigned N_BANKS    = 16,
   parameter  int unsigned BANK_WORDS = 128,
   localparam int unsigned BANK_B     = $clog2(N_BANKS),
   localparam int unsigned ROW_B      = $clog2(BANK_WORDS),
   localparam int unsigned WADDR_W    = BANK_B + ROW_B
) (
   input  logic [WADDR_W-1:0] word_addr,
   input  bxb_pkg::map_mode_e mode,
   output logic [BANK_B-1:0]  bank,
   output logic [ROW_B-1:0]   row
);
   always_comb begin
      if (mode == bxb_pkg::MAP_BLOCKED) begin
         bank = word_addr[WADDR_W-1 -: BANK_B];
         row  = word_addr[ROW_B-1:0];
      end else begin
         bank = word_addr[BANK_B-1:0];
         row  = word_addr[WADDR_W-1 -: ROW_B];
      end
   end
endmodule

// File: rtl/bxb_rr_arb.sv
`timescale 1ns/1ps
// Round-robin arbiter for one bank; the pointer moves only on a grant.
module bxb_rr_arb #(
   parameter  int unsigned N_REQ = 20,
   localparam int unsigned IDX_W = $clog2(N_REQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   output logic [N_REQ-1:0] gnt,
   output logic             gnt_any,
   output logic [IDX_W-1:0] gnt_idx
);
   logic [IDX_W-1:0] ptr_q;

   always_comb begin
      gnt     = '0;
      gnt_any = 1'b0;
      gnt_idx = '0;
      for (int unsigned k = 0; k < N_REQ; k++) begin
         logic [IDX_W:0] cand;
         cand = {1'b0, ptr_q} + (IDX_W+1)'(k);
         if (cand >= (IDX_W+1)'(N_REQ)) begin
            cand = cand - (IDX_W+1)'(N_REQ);
         end
         if (!gnt_any && req[cand[IDX_W-1:0]]) begin
            gnt_any = 1'b1;
            gnt_idx = cand[IDX_W-1:0];
         end
      end
      if (gnt_any) begin
         gnt[gnt_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (gnt_any) begin
         ptr_q <= (gnt_idx == IDX_W'(N_REQ-1)) ? '0 : gnt_idx + 1'b1;
      end
   end
endmodule

// File: rtl/bxb_bank_ram.sv
`timescale 1ns/1ps
// One synchronous bank: byte-masked write or registered read per cycle.
module bxb_bank_ram #(
   parameter  int unsigned WORD_BYTES = 8,
   parameter  int unsigned ROWS       = 128,
   localparam int unsigned DATA_W     = WORD_BYTES * 8,
   localparam int unsigned ROW_B      = $clog2(ROWS)
) (
   input  logic                  clk,
   input  logic                  en,
   input  logic                  we,
   input  logic [ROW_B-1:0]      row,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [WORD_BYTES-1:0] be,
   output logic [DATA_W-1:0]     rdata
);
   logic [DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            for (int i = 0; i < int'(WORD_BYTES); i++) begin
               if (be[i]) begin
                  mem[row][i*8 +: 8] <= wdata[i*8 +: 8];
               end
            end
         end else begin
            rdata <= mem[row];
         end
      end
   end
endmodule

// File: rtl/banked_xbar.sv
`timescale 1ns/1ps
module banked_xbar
   import bxb_pkg::*;
#(
   parameter  int unsigned N_MASTERS  = DEF_MASTERS,
   parameter  int unsigned N_BANKS    = DEF_BANKS,
   parameter  int unsigned WORD_BYTES = DEF_WORD_BYTES,
   parameter  int unsigned BANK_WORDS = DEF_BANK_WORDS,
   localparam int unsigned DATA_W     = WORD_BYTES * 8,
   localparam int unsigned BANK_B     = $clog2(N_BANKS),
   localparam int unsigned ROW_B      = $clog2(BANK_WORDS),
   localparam int unsigned WADDR_W    = BANK_B + ROW_B,
   localparam int unsigned MIDX_W     = $clog2(N_MASTERS)
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  map_blocked,
   input  logic [N_MASTERS-1:0]                  req_valid,
   input  logic [N_MASTERS-1:0]                  req_write,
   input  logic [N_MASTERS-1:0][WADDR_W-1:0]     req_addr,
   input  logic [N_MASTERS-1:0][DATA_W-1:0]      req_wdata,
   input  logic [N_MASTERS-1:0][WORD_BYTES-1:0]  req_be,
   output logic [N_MASTERS-1:0]                  req_grant,
   output logic [N_MASTERS-1:0]                  rsp_valid,
   output logic [N_MASTERS-1:0][DATA_W-1:0]      rsp_rdata
);
   // elaboration-time parameter checks
   if (N_MASTERS < 2) begin : g_bad_masters
      $error("banked_xbar: N_MASTERS must be at least 2");
   end
   if (N_BANKS < 2 || (N_BANKS & (N_BANKS - 1)) != 0) begin : g_bad_banks
      $error("banked_xbar: N_BANKS must be a power of two, at least 2");
   end
   if (BANK_WORDS < 2 || (BANK_WORDS & (BANK_WORDS - 1)) != 0) begin : g_bad_depth
      $error("banked_xbar: BANK_WORDS must be a power of two, at least 2");
   end
   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("banked_xbar: WORD_BYTES must be a power of two");
   end

   map_mode_e mode;
   assign mode = map_mode_e'(map_blocked);

   // per-requester address decode
   logic [N_MASTERS-1:0][BANK_B-1:0] m_bank;
   logic [N_MASTERS-1:0][ROW_B-1:0]  m_row;

   for (genvar m = 0; m < N_MASTERS; m++) begin : g_map
      bxb_bank_map #(
         .N_BANKS    (N_BANKS),
         .BANK_WORDS (BANK_WORDS)
      ) u_map (
         .word_addr (req_addr[m]),
         .mode      (mode),
         .bank      (m_bank[m]),
         .row       (m_row[m])
      );
   end

   // per-bank request vectors, arbiters and storage
   logic [N_BANKS-1:0][N_MASTERS-1:0] b_req;
   logic [N_BANKS-1:0][N_MASTERS-1:0] b_gnt;
   logic [N_BANKS-1:0]                b_any;
   logic [N_BANKS-1:0][MIDX_W-1:0]    b_idx;
   logic [N_BANKS-1:0][DATA_W-1:0]    b_rdata;

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      for (genvar m = 0; m < N_MASTERS; m++) begin : g_req
         assign b_req[b][m] = req_valid[m] && (m_bank[m] == BANK_B'(b));
      end

      bxb_rr_arb #(
         .N_REQ (N_MASTERS)
      ) u_arb (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (b_req[b]),
         .gnt     (b_gnt[b]),
         .gnt_any (b_any[b]),
         .gnt_idx (b_idx[b])
      );

      logic                  sel_we;
      logic [ROW_B-1:0]      sel_row;
      logic [DATA_W-1:0]     sel_wdata;
      logic [WORD_BYTES-1:0] sel_be;

      assign sel_we    = req_write[b_idx[b]];
      assign sel_row   = m_row[b_idx[b]];
      assign sel_wdata = req_wdata[b_idx[b]];
      assign sel_be    = req_be[b_idx[b]];

      bxb_bank_ram #(
         .WORD_BYTES (WORD_BYTES),
         .ROWS       (BANK_WORDS)
      ) u_ram (
         .clk   (clk),
         .en    (b_any[b]),
         .we    (sel_we),
         .row   (sel_row),
         .wdata (sel_wdata),
         .be    (sel_be),
         .rdata (b_rdata[b])
      );
   end

   // grant return: each requester sees the grant of the bank it targets
   always_comb begin
      req_grant = '0;
      for (int m = 0; m < int'(N_MASTERS); m++) begin
         for (int b = 0; b < int'(N_BANKS); b++) begin
            req_grant[m] = req_grant[m] | b_gnt[b][m];
         end
      end
   end

   // read return: remember which bank each granted read went to
   logic [N_MASTERS-1:0]             rsp_q;
   logic [N_MASTERS-1:0][BANK_B-1:0] src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q <= '0;
         src_q <= '0;
      end else begin
         rsp_q <= req_grant & ~req_write;
         src_q <= m_bank;
      end
   end

   assign rsp_valid = rsp_q;

   always_comb begin
      for (int m = 0; m < int'(N_MASTERS); m++) begin
         rsp_rdata[m] = rsp_q[m] ? b_rdata[src_q[m]] : '0;
      end
   end
endmodule

// File: rtl/banked_xbar_chk.sv
`timescale 1ns/1ps
module banked_xbar_chk #(
   parameter  int unsigned N_MASTERS  = 20,
   parameter  int unsigned N_BANKS    = 16,
   parameter  int unsigned WORD_BYTES = 8,
   parameter  int unsigned BANK_WORDS = 128,
   localparam int unsigned DATA_W     = WORD_BYTES * 8,
   localparam int unsigned BANK_B     = $clog2(N_BANKS),
   localparam int unsigned ROW_B      = $clog2(BANK_WORDS),
   localparam int unsigned WADDR_W    = BANK_B + ROW_B
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              map_blocked,
   input logic [N_MASTERS-1:0]              req_valid,
   input logic [N_MASTERS-1:0]              req_write,
   input logic [N_MASTERS-1:0][WADDR_W-1:0] req_addr,
   input logic [N_MASTERS-1:0]              req_grant,
   input logic [N_MASTERS-1:0]              rsp_valid,
   input logic [N_MASTERS-1:0][DATA_W-1:0]  rsp_rdata
);
   logic [N_MASTERS-1:0][BANK_B-1:0]  tgt;
   logic [N_BANKS-1:0][N_MASTERS-1:0] on_bank;
   logic [N_MASTERS-1:0]              alone;

   always_comb begin
      for (int m = 0; m < int'(N_MASTERS); m++) begin
         tgt[m] = map_blocked ? req_addr[m] >> ROW_B : req_addr[m] % N_BANKS;
      end
      for (int b = 0; b < int'(N_BANKS); b++) begin
         for (int m = 0; m < int'(N_MASTERS); m++) begin
            on_bank[b][m] = req_valid[m] && (int'(tgt[m]) == b);
         end
      end
      for (int m = 0; m < int'(N_MASTERS); m++) begin
         alone[m] = ($countones(on_bank[tgt[m]]) == 1);
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (rsp_valid == '0));

   assert_mode_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |-> $stable(map_blocked));

   for (genvar b = 0; b < N_BANKS; b++) begin : g_b
      assert_one_grant_per_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(req_grant & on_bank[b]) <= 1);
   end

   for (genvar m = 0; m < N_MASTERS; m++) begin : g_m
      assert_grant_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
         req_grant[m] |-> req_valid[m]);
      assert_hold_until_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[m] && !req_grant[m]) |=>
            (req_valid[m] && $stable(req_addr[m]) && $stable(req_write[m])));
      assert_lone_bank_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[m] && alone[m]) |-> req_grant[m]);
      assert_read_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (req_grant[m] && !req_write[m]) |=> rsp_valid[m]);
      assert_no_spurious_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !(req_grant[m] && !req_write[m]) |=> !rsp_valid[m]);
      assert_idle_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !rsp_valid[m] |-> (rsp_rdata[m] == '0));
   end
endmodule

bind banked_xbar banked_xbar_chk #(
   .N_MASTERS  (N_MASTERS),
   .N_BANKS    (N_BANKS),
   .WORD_BYTES (WORD_BYTES),
   .BANK_WORDS (BANK_WORDS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .map_blocked (map_blocked),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .req_grant   (req_grant),
   .rsp_valid   (rsp_valid),
   .rsp_rdata   (rsp_rdata)
);

// File: tb/banked_xbar_tb_top.sv
`timescale 1ns/1ps
module banked_xbar_tb_top;
   localparam int NM = 20;
   localparam int NB = 16;
   localparam int RW = 128;
   localparam int NW = NB * RW;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                map_blocked = 1'b0;
   logic [NM-1:0]       req_valid = '0;
   logic [NM-1:0]       req_write = '0;
   logic [NM-1:0][10:0] req_addr = '0;
   logic [NM-1:0][63:0] req_wdata = '0;
   logic [NM-1:0][7:0]  req_be = '0;
   logic [NM-1:0]       req_grant;
   logic [NM-1:0]       rsp_valid;
   logic [NM-1:0][63:0] rsp_rdata;

   int n_chk = 0;
   int n_bad = 0;
   logic [63:0] mdl [NB][RW];
   int rr_ptr [NB];

   always #2 clk = ~clk;

   banked_xbar dut_i (
      .clk (clk), .rst_n (rst_n), .map_blocked (map_blocked),
      .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
      .req_wdata (req_wdata), .req_be (req_be), .req_grant (req_grant),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] pat(input int w);
      return (64'h9E37_79B9_7F4A_7C15 * 64'(w + 1)) ^ 64'(w << 40);
   endfunction

   task automatic clr();
      req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0; req_be = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; clr();
      end
   endtask

   task automatic set_mode(input logic v);
      @(posedge clk); #1; clr(); map_blocked = v;
      idle(1);
   endtask

   // one request per listed requester, all expected to be granted together
   task automatic grp(input logic [NM-1:0] mask, input logic [NM-1:0] wr,
                      input logic [10:0] ad [NM], input logic [63:0] dat [NM], input string tag);
      @(posedge clk); #1; clr();
      req_valid = mask; req_write = wr;
      for (int m = 0; m < NM; m++) begin
         req_addr[m] = ad[m]; req_wdata[m] = dat[m]; req_be[m] = 8'hFF;
      end
      @(negedge clk);
      chk(req_grant == mask, {"R4 distinct banks all granted ", tag}, 64'(req_grant), 64'(mask));
      @(posedge clk); #1; clr();
      @(negedge clk);
      chk(rsp_valid == (mask & ~wr), {"R7 response lanes ", tag}, 64'(rsp_valid), 64'(mask & ~wr));
      for (int m = 0; m < NM; m++) begin
         if (mask[m] && !wr[m]) begin
            chk(rsp_rdata[m] === dat[m], {"R7 read data ", tag}, rsp_rdata[m], dat[m]);
         end
      end
   endtask

   task automatic one_wr(input int m, input logic [10:0] a, input logic [63:0] d, input logic [7:0] be);
      @(posedge clk); #1; clr();
      req_valid[m] = 1'b1; req_write[m] = 1'b1; req_addr[m] = a; req_wdata[m] = d; req_be[m] = be;
      @(negedge clk);
      chk(req_grant[m], "R4 lone write granted", 64'(req_grant), 64'(1) << m);
      @(posedge clk); #1; clr();
      @(negedge clk);
      chk(rsp_valid == '0, "R7 write gives no response", 64'(rsp_valid), 64'h0);
   endtask

   task automatic one_rd(input int m, input logic [10:0] a, input logic [63:0] exp, input string tag);
      @(posedge clk); #1; clr();
      req_valid[m] = 1'b1; req_addr[m] = a;
      @(negedge clk);
      chk(req_grant[m], {"R4 lone read granted ", tag}, 64'(req_grant), 64'(1) << m);
      @(posedge clk); #1; clr();
      @(negedge clk);
      chk(rsp_valid[m], {"R7 response valid ", tag}, 64'(rsp_valid), 64'(1) << m);
      chk(rsp_rdata[m] === exp, {"data ", tag}, rsp_rdata[m], exp);
   endtask

   // requester 0 on word 0 against requester 1 on every word
   task automatic sweep(input bit blocked, input string tag);
      for (int a = 0; a < NW; a++) begin
         logic [10:0] wa;
         bit differ;
         logic [1:0] left;
         wa = 11'(a);
         differ = blocked ? (wa[10:7] != 4'd0) : (wa[3:0] != 4'd0);
         @(posedge clk); #1; clr();
         req_valid[1:0] = 2'b11; req_addr[0] = '0; req_addr[1] = wa;
         @(negedge clk);
         chk($countones(req_grant[1:0]) == (differ ? 2 : 1), {tag, " bank conflict pattern, R5"},
             64'(req_grant[1:0]), differ ? 64'd3 : 64'd1);
         left = ~req_grant[1:0];
         if (left != 2'b00) begin
            @(posedge clk); #1; clr();
            req_valid[1:0] = left; req_addr[0] = '0; req_addr[1] = wa;
            @(negedge clk);
         end
      end
      idle(1);
   endtask

   function automatic logic [NM-1:0] rr_expect(input int b, input logic [NM-1:0] p);
      for (int k = 0; k < NM; k++) begin
         int idx;
         idx = (rr_ptr[b] + k) % NM;
         if (p[idx]) return NM'(1) << idx;
      end
      return '0;
   endfunction

   // requesters in 'set' all aim at interleaved bank 0 until served
   task automatic rr_round(input logic [NM-1:0] set, input logic [NM-1:0] wr);
      logic [NM-1:0] pend;
      logic [NM-1:0] exp;
      pend = set;
      for (int guard = 0; guard < 2 * NM && pend != '0; guard++) begin
         @(posedge clk); #1; clr();
         req_valid = pend; req_write = wr & pend;
         for (int m = 0; m < NM; m++) begin
            req_addr[m] = 11'(m * NB); req_wdata[m] = pat(m); req_be[m] = 8'hFF;
         end
         @(negedge clk);
         exp = rr_expect(0, pend);
         chk(req_grant == exp, "R6 round-robin winner, R5 single grant", 64'(req_grant), 64'(exp));
         for (int m = 0; m < NM; m++) if (exp[m]) rr_ptr[0] = (m + 1) % NM;
         pend = pend & ~req_grant;
      end
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [10:0] ad [NM];
      logic [63:0] dat [NM];
      logic [NM-1:0] mask;
      logic [63:0] cur;
      logic [63:0] nv;
      logic [7:0] be;

      // R1: reset state
      clr(); rst_n = 1'b0; map_blocked = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rsp_valid == '0, "R1 no response in reset", 64'(rsp_valid), 64'h0);
      chk(req_grant == '0, "R1 no grant in reset", 64'(req_grant), 64'h0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == '0, "R1 no response after reset", 64'(rsp_valid), 64'h0);

      // R2/R4: fill all words, 16 requesters on 16 interleaved banks per cycle
      for (int g = 0; g < RW; g++) begin
         for (int m = 0; m < NM; m++) begin ad[m] = '0; dat[m] = '0; end
         for (int m = 0; m < NB; m++) begin
            ad[m] = 11'(g * NB + m);
            dat[m] = pat(g * NB + m);
            mdl[m][g] = dat[m];
         end
         grp(NM'(20'h0FFFF), NM'(20'h0FFFF), ad, dat, "R2 interleaved fill");
      end

      // R2/R7: read back with shifted requesters and rotated words
      for (int g = 0; g < RW; g++) begin
         for (int m = 0; m < NM; m++) begin ad[m] = '0; dat[m] = '0; end
         for (int k = 0; k < NB; k++) begin
            int w;
            w = g * NB + ((k + g) % NB);
            ad[k + 4] = 11'(w);
            dat[k + 4] = mdl[w % NB][w / NB];
         end
         grp(NM'(20'hFFFF0), '0, ad, dat, "R2 interleaved readback");
      end

      // R8: byte-mask sweep on word 83 (bank 3, row 5)
      cur = mdl[3][5];
      for (int k = 0; k <= 8; k++) begin
         be = (k < 8) ? 8'(1 << k) : 8'h00;
         nv = ~pat(1000 + k);
         one_wr(19, 11'd83, nv, be);
         for (int i = 0; i < 8; i++) if (be[i]) cur[i*8 +: 8] = nv[i*8 +: 8];
         mdl[3][5] = cur;
         one_rd(19, 11'd83, cur, "R8 byte mask");
      end

      // R2/R5: conflict sweep under interleaved map
      sweep(1'b0, "R2 interleaved");

      // R10/R3: switch while idle, conflict sweep under blocked map
      set_mode(1'b1);
      sweep(1'b1, "R3 blocked");

      // R3/R10: read every physical cell through the blocked map
      for (int r = 0; r < RW; r++) begin
         for (int m = 0; m < NM; m++) begin ad[m] = '0; dat[m] = '0; end
         for (int b = 0; b < NB; b++) begin
            ad[b] = 11'(b * RW + r);
            dat[b] = mdl[b][r];
         end
         grp(NM'(20'h0FFFF), '0, ad, dat, "R3 R10 blocked readback");
      end

      // R10: write under blocked map, read same cell under interleaved map
      nv = 64'hA5C3_0F1E_2D3C_4B5A;
      one_wr(2, 11'(9 * RW + 5), nv, 8'hFF);
      mdl[9][5] = nv;
      set_mode(1'b0);
      one_rd(6, 11'(5 * NB + 9), nv, "R10 cross-map cell");

      // R1/R6: fresh reset, then arbitration order on bank 0
      @(posedge clk); #1; clr(); rst_n = 1'b0;
      idle(2);
      @(posedge clk); #1; rst_n = 1'b1;
      for (int b = 0; b < NB; b++) rr_ptr[b] = 0;
      mask = '1;
      rr_round(mask, 20'h00000);
      idle(4);
      rr_round(20'h08088, 20'h00080);
      idle(3);
      rr_round(20'h00024, 20'h00004);
      idle(5);
      rr_round(20'h80011, 20'h00001);
      rr_round(20'h0F0F0, 20'h05050);

      idle(2);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule